// File: doc/BRIEF.md
# Overflow-Armed Branch Sample Buffer

This block gathers taken-branch samples for statistical profiling without keeping a trace running all the time. An internal event counter is loaded with a fixed sampling period and counts down once per event pulse. When the counter wraps, the block arms a sixteen-slot capture store. The store then takes the source and target address of every retired taken branch until all sixteen slots hold data. Only at that point does the interrupt rise.

Software reads the slots through a combinational read port, with the newest branch at index 0, together with the fill count and a full flag. A re-arm command empties the store, drops the interrupt and restarts the period. Writing a new period has the same effect. Periods of sixteen or less are reported as invalid and never arm capture.

The branch input is a valid/ready stream. `br_ready` is high at all times outside reset, so the block never back-pressures the retire path. A branch offered while capture is not armed, or after the store is full, is accepted and then discarded.

Top module: `tbr_sampler`

## Requirements
- R1: After reset, `fill_count` is 0, `irq` and `buf_full` are 0, `period_bad` is 1 (the period register resets to 0), `br_ready` is 1 and every read returns zero.
- R2: A stored period that is not greater than 16 sets `period_bad`, and with `period_bad` set no branch is ever captured.
- R3: Writing a period loads the counter with it. The counter overflows on the P-th event pulse after that load, and branches offered before the overflow are not recorded.
- R4: A branch offered in the same cycle as the overflow is not recorded. Capture starts with the next branch handshake.
- R5: While armed, each branch handshake (`br_valid` with `br_ready`) is recorded and raises `fill_count` by one in the following cycle. There is no filtering of any kind.
- R6: Once 16 branches are held, further branches are dropped and the stored contents and `fill_count` stay unchanged.
- R7: `irq` and `buf_full` rise in the cycle after the 16th capture and stay high until a re-arm or a period write.
- R8: With `rd_addr` set to k, the read port returns the (k+1)-th most recent captured branch: 0 is the newest and `fill_count`-1 is the oldest. For k ≥ `fill_count` it returns zero in both address fields.
- R9: The counter keeps running while the store fills and reloads itself on each overflow. An overflow during capture or while full has no effect on the store.
- R10: `rearm` clears `fill_count` and `irq` in the next cycle and reloads the counter, so the next overflow needs a full period of events.
- R11: A period write also clears the store and `irq` and restarts the count from the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_pulse | input | 1 | One pulse per counted event |
| br_valid | input | 1 | Retired taken branch offered |
| br_ready | output | 1 | Branch accept, high outside reset |
| br_from | input | AW | Branch source address |
| br_to | input | AW | Branch target address |
| cfg_we | input | 1 | Write the sampling period |
| cfg_period | input | CW | Sampling period value |
| rearm | input | 1 | Clear the store and restart the period |
| rd_addr | input | 4 | Read index, 0 is the newest |
| rd_from | output | AW | Source address at `rd_addr` |
| rd_to | output | AW | Target address at `rd_addr` |
| fill_count | output | 5 | Number of captured branches |
| buf_full | output | 1 | All 16 slots hold data |
| period_bad | output | 1 | Stored period is 16 or less |
| irq | output | 1 | Sample ready interrupt |

## Verification
The bench aims at the exact overflow event. One event too early or too late would show up as captured branches in a row that should read empty, or as a fill count that is off by one. A branch that coincides with the overflow cycle is checked to be dropped, which catches a design that arms combinationally.

Saturation is tested by sending 25 branches and reading the oldest and newest slots. A wrapping store would return branches 9 and 24 instead of 0 and 15. Reads past the fill count must return zero, and a reversed read order would swap those slots.

A second overflow in the middle of capture, a re-arm partway through a count, and a period write are each exercised. They would expose a store that restarts, or a counter that is not reloaded.

// File: rtl/tbr_pkg.sv
package tbr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CAPT = 2'd1,
    ST_FULL = 2'd2
  } cap_state_e;
endpackage

// File: rtl/tbr_event_ctr.sv
module tbr_event_ctr #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          ovf
);
  logic [CW-1:0] cnt_q;
  logic          wrap;

  assign wrap = (cnt_q <= CW'(1));
  assign ovf  = ev && !load && wrap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (ev) begin
      if (wrap) cnt_q <= load_val;
      else      cnt_q <= cnt_q - CW'(1);
    end
  end

  // R9
  reload_after_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> (cnt_q == $past(load_val)));
endmodule

// File: rtl/tbr_capture_buf.sv
module tbr_capture_buf
  import tbr_pkg::*;
#(
  parameter int AW    = 48,
  parameter int DEPTH = 16,
  parameter int IW    = $clog2(DEPTH),
  parameter int FW    = IW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic          clear,
  input  logic          br_valid,
  input  logic [AW-1:0] br_from,
  input  logic [AW-1:0] br_to,
  input  logic [IW-1:0] rd_addr,
  output logic [AW-1:0] rd_from,
  output logic [AW-1:0] rd_to,
  output logic [FW-1:0] fill,
  output logic          full
);
  cap_state_e    st_q;
  logic [FW-1:0] fill_q;
  logic          cap_we;
  logic [IW-1:0] wr_idx;
  logic [AW-1:0] from_q [DEPTH];
  logic [AW-1:0] to_q   [DEPTH];
  logic [FW-1:0] diff;
  logic [IW-1:0] rd_idx;
  logic          rd_hit;

  assign cap_we = (st_q == ST_CAPT) && br_valid && !clear;
  assign wr_idx = fill_q[IW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      fill_q <= '0;
    end else if (clear) begin
      st_q   <= ST_IDLE;
      fill_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (arm) st_q <= ST_CAPT;
        ST_CAPT: if (cap_we) begin
          fill_q <= fill_q + FW'(1);
          if (fill_q == FW'(DEPTH - 1)) st_q <= ST_FULL;
        end
        default: st_q <= st_q;
      endcase
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (cap_we && (wr_idx == IW'(g))) begin
        from_q[g] <= br_from;
        to_q[g]   <= br_to;
      end
    end
  end

  assign diff    = fill_q - {1'b0, rd_addr} - FW'(1);
  assign rd_idx  = diff[IW-1:0];
  assign rd_hit  = ({1'b0, rd_addr} < fill_q);
  assign rd_from = rd_hit ? from_q[rd_idx] : '0;
  assign rd_to   = rd_hit ? to_q[rd_idx]   : '0;
  assign fill    = fill_q;
  assign full    = (st_q == ST_FULL);

  // R6
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= FW'(DEPTH));
  // R6
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_FULL && !clear) |=> ($stable(fill_q) && st_q == ST_FULL));
  // R4
  arm_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && !clear) |=> (fill_q == '0));
  // R5
  fill_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_CAPT && br_valid && !clear) |=> (fill_q == $past(fill_q) + FW'(1)));
endmodule

// File: rtl/tbr_sampler.sv
module tbr_sampler #(
  parameter int AW    = 48,
  parameter int CW    = 32,
  parameter int DEPTH = 16,
  localparam int IW   = $clog2(DEPTH),
  localparam int FW   = IW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_pulse,
  input  logic          br_valid,
  output logic          br_ready,
  input  logic [AW-1:0] br_from,
  input  logic [AW-1:0] br_to,
  input  logic          cfg_we,
  input  logic [CW-1:0] cfg_period,
  input  logic          rearm,
  input  logic [IW-1:0] rd_addr,
  output logic [AW-1:0] rd_from,
  output logic [AW-1:0] rd_to,
  output logic [FW-1:0] fill_count,
  output logic          buf_full,
  output logic          period_bad,
  output logic          irq
);
  logic [CW-1:0] period_q;
  logic [CW-1:0] load_val;
  logic          ctr_load;
  logic          ovf;
  logic          arm;
  logic          clr;
  logic          full;

  always_ff @(posedge clk) begin
    if (!rst_n)      period_q <= '0;
    else if (cfg_we) period_q <= cfg_period;
  end

  assign period_bad = !(period_q > CW'(DEPTH));
  assign ctr_load   = rearm || cfg_we;
  assign clr        = rearm || cfg_we;
  assign load_val   = cfg_we ? cfg_period : period_q;
  assign arm        = ovf && !period_bad;
  assign br_ready   = rst_n;

  tbr_event_ctr #(.CW(CW)) i_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev       (ev_pulse),
    .load     (ctr_load),
    .load_val (load_val),
    .ovf      (ovf)
  );

  tbr_capture_buf #(.AW(AW), .DEPTH(DEPTH)) i_buf (
    .clk      (clk),
    .rst_n    (rst_n),
    .arm      (arm),
    .clear    (clr),
    .br_valid (br_valid),
    .br_from  (br_from),
    .br_to    (br_to),
    .rd_addr  (rd_addr),
    .rd_from  (rd_from),
    .rd_to    (rd_to),
    .fill     (fill_count),
    .full     (full)
  );

  assign buf_full = full;
  assign irq      = full;

  // R7
  irq_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (fill_count == FW'(DEPTH)));
  // R10
  rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rearm |=> (fill_count == '0 && !irq));
  // R2
  bad_noarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (period_bad && !cfg_we) |=> (fill_count == '0));
  // R11
  cfg_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (fill_count == '0 && !irq));
endmodule

// File: tb/test_tbr_sampler.sv
module test_tbr_sampler;
  localparam int CLK_PERIOD = 10;
  localparam int NROW = 7;
  localparam int T_PER [NROW] = '{20, 20, 17, 17, 16, 5, 30};
  localparam int T_EV  [NROW] = '{19, 20, 17, 17, 40, 10, 60};
  localparam int T_BR  [NROW] = '{5, 5, 16, 25, 10, 4, 3};
  localparam int T_FIL [NROW] = '{0, 5, 16, 16, 0, 0, 3};
  localparam int T_IRQ [NROW] = '{0, 0, 1, 1, 0, 0, 0};

  logic        clk = 0;
  logic        rst_n = 0;
  logic        ev_pulse = 0, br_valid = 0, cfg_we = 0, rearm = 0;
  logic        br_ready;
  logic [47:0] br_from = '0, br_to = '0;
  logic [31:0] cfg_period = '0;
  logic [3:0]  rd_addr = '0;
  logic [47:0] rd_from, rd_to;
  logic [4:0]  fill_count;
  logic        buf_full, period_bad, irq;
  int          checks = 0, errs = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tbr_sampler i_tbr_sampler (
    .clk(clk), .rst_n(rst_n), .ev_pulse(ev_pulse), .br_valid(br_valid),
    .br_ready(br_ready), .br_from(br_from), .br_to(br_to), .cfg_we(cfg_we),
    .cfg_period(cfg_period), .rearm(rearm), .rd_addr(rd_addr),
    .rd_from(rd_from), .rd_to(rd_to), .fill_count(fill_count),
    .buf_full(buf_full), .period_bad(period_bad), .irq(irq)
  );

  function automatic logic [47:0] mkf(int r, int i);
    return 48'h1000_0000 + 48'(r) * 48'h1_0000 + 48'(i) * 48'h4;
  endfunction
  function automatic logic [47:0] mkt(int r, int i);
    return mkf(r, i) ^ 48'h0000_00FF_0000;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
    ev_pulse = 0; br_valid = 0; cfg_we = 0; rearm = 0;
  endtask
  task automatic set_period(int p);
    cfg_period = 32'(p); cfg_we = 1; step();
  endtask
  task automatic events(int n);
    for (int k = 0; k < n; k++) begin ev_pulse = 1; step(); end
  endtask
  task automatic branch(int r, int i);
    br_valid = 1; br_from = mkf(r, i); br_to = mkt(r, i); step();
  endtask
  task automatic do_rearm();
    rearm = 1; step();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errs++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    chk("R1 fill", 64'(fill_count), 0);
    chk("R1 irq", 64'(irq), 0);
    chk("R1 full", 64'(buf_full), 0);
    chk("R1 period_bad", 64'(period_bad), 1);
    chk("R1 br_ready", 64'(br_ready), 1);
    chk("R1 rd_from", 64'(rd_from), 0);

    // Table walk: R2 R3 R5 R6 R7 R9
    for (int r = 0; r < NROW; r++) begin
      set_period(T_PER[r]);
      events(T_EV[r]);
      for (int i = 0; i < T_BR[r]; i++) branch(r, i);
      chk($sformatf("R3/R5/R6 row%0d fill", r), 64'(fill_count), 64'(T_FIL[r]));
      chk($sformatf("R7 row%0d irq", r), 64'(irq), 64'(T_IRQ[r]));
      chk($sformatf("R2 row%0d bad", r), 64'(period_bad), 64'(T_PER[r] <= 16));
      if (r == 1) begin
        // R8 order and zero past fill
        rd_addr = 0; #1 chk("R8 newest", 64'(rd_from), 64'(mkf(1, 4)));
        rd_addr = 4; #1 chk("R8 oldest", 64'(rd_to), 64'(mkt(1, 0)));
        rd_addr = 5; #1 chk("R8 beyond fill", 64'(rd_from), 0);
      end
      if (r == 3) begin
        // R6 saturation keeps first sixteen
        rd_addr = 0;  #1 chk("R6 newest kept", 64'(rd_from), 64'(mkf(3, 15)));
        rd_addr = 15; #1 chk("R6 oldest kept", 64'(rd_to), 64'(mkt(3, 0)));
      end
    end

    // R4 branch in overflow cycle dropped
    set_period(17);
    events(16);
    ev_pulse = 1; br_valid = 1; br_from = mkf(9, 0); br_to = mkt(9, 0); step();
    branch(9, 1);
    rd_addr = 0; #1;
    chk("R4 fill", 64'(fill_count), 1);
    chk("R4 first captured", 64'(rd_from), 64'(mkf(9, 1)));

    // R7 irq timing
    for (int i = 2; i < 16; i++) branch(9, i);
    chk("R7 irq low at 15", 64'(irq), 0);
    branch(9, 16);
    chk("R7 irq high at 16", 64'(irq), 1);
    chk("R7 full", 64'(buf_full), 1);
    events(40);
    chk("R9 full unaffected", 64'(fill_count), 16);

    // R10 rearm and counter reload
    do_rearm();
    chk("R10 fill cleared", 64'(fill_count), 0);
    chk("R10 irq cleared", 64'(irq), 0);
    events(16);
    branch(10, 0);
    chk("R10 not yet armed", 64'(fill_count), 0);
    events(1);
    branch(10, 1);
    chk("R10 armed after period", 64'(fill_count), 1);

    // R11 period write reloads counter
    set_period(20);
    chk("R11 cleared", 64'(fill_count), 0);
    events(15);
    set_period(25);
    events(20);
    branch(11, 0);
    chk("R11 no early overflow", 64'(fill_count), 0);
    events(5);
    branch(11, 1);
    chk("R11 overflow at new period", 64'(fill_count), 1);

    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end
endmodule